// File: doc/BRIEF.md
# Sensor Row Zero-Bias Corrector

This block sits between an image sensor's parallel pixel output and a microcontroller's memory bus. When the processor invokes it, it captures one frame of 64 rows. Every row arrives as 66 bytes: 64 live pixels first, then 2 pixels from optically masked columns. The masked pixels should read zero. Any reading above zero is an offset that applies to the whole row. After each row is captured, the block averages that row's two masked pixels and subtracts the average from each of the 64 live pixels, stored in place. The frame then stays in an internal buffer that the processor reads at memory-mapped addresses.

Pixels are unsigned 8-bit intensities, where 0 means no light and 255 means full exposure. A 1-cycle start pulse begins a frame. A valid strobe qualifies each sensor byte. The processor polls a busy bit on the same bus and reads the buffer when the frame is done.

Top module: `zb_row_corrector`

## Requirements
- R1: After reset the block is idle, `bus_rdata` is 0 and the status location reads 0. Pixel strobes in idle store nothing and do not start a frame.
- R2: A `start` pulse in idle clears the row and column indices to 0 and begins capture. A `start` while busy is ignored. A later frame fully overwrites the previous one.
- R3: During capture, each cycle with `pix_valid` high accepts one byte. Cycles with it low do not advance. The first 64 bytes of a row are live pixels for columns 0 to 63, and bytes 65 and 66 are the masked pair.
- R4: The row offset is the sum of the row's two masked bytes divided by 2, truncated toward zero.
- R5: Each stored pixel is (live pixel minus row offset), computed signed and clamped at 0.
- R6: Each row takes a fixed sequence after its 66th accepted byte: 1 offset cycle, 64 correction cycles (one per column), then 1 row-advance cycle. Strobes during these cycles are ignored. With no strobe gaps, a frame keeps the block busy for exactly 64 x 132 = 8448 cycles.
- R7: Busy is set from the cycle after an accepted start until the row-advance cycle of row 63 ends, and the block then returns to idle.
- R8: A read (`bus_rd` high) returns data on `bus_rdata` in the following cycle, and the value is held until the next read.
  - Addresses 0 to 4095 return the corrected byte at row*64 + column.
  - Address 4096 returns busy in bit 0, with the other bits 0.
  - All other addresses return 0.
- R9: A read of a buffer location in the same cycle that the correction step writes that location returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request |
| pix_valid | input | 1 | Qualifies `pix_data` this cycle |
| pix_data | input | 8 | Sensor byte |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 13 | Read address (buffer or status) |
| bus_rdata | output | 8 | Registered read data |

## Verification
Two functions can meet in one cycle: the processor reading a buffer location, and the correction step rewriting that same location.

The bench provokes this while a frame is in progress. During the correction phase it aims reads at the exact location being corrected in that cycle, and it mixes these with status polls and reads of rows that are already finished. A cycle-level reference model in the bench predicts every `bus_rdata` value, so the bench can judge whether a colliding read returned the pre-write byte.

A separate gap-free frame polls the status location on every cycle and counts the busy cycles. Throughout that frame, junk strobes are driven outside the capture phase.

// File: rtl/zb_pkg.sv
package zb_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PIX_W     = 8;
  localparam int DARK_COLS = 2;

  typedef enum logic [2:0] {ST_IDLE, ST_GET, ST_BIAS, ST_FIX, ST_NEXT} zb_state_t;

  // mean of the two masked samples, truncated
  function automatic logic [PIX_W-1:0] row_offset(input logic [PIX_W-1:0] a,
                                                  input logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PIX_W:1];
  endfunction

  // signed difference, floored at zero
  function automatic logic [PIX_W-1:0] sub_clamp(input logic [PIX_W-1:0] px,
                                                 input logic [PIX_W-1:0] off);
    logic signed [PIX_W+1:0] d;
    d = $signed({2'b00, px}) - $signed({2'b00, off});
    return (d < 0) ? '0 : d[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/zb_ctrl.sv
module zb_ctrl
  import zb_pkg::*;
#(
  parameter int ROWS     = 64,
  parameter int ACT_COLS = 64,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(ACT_COLS + DARK_COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pix_valid,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             busy,
  output logic             cap_we,
  output logic             cap_dark0,
  output logic             cap_dark1,
  output logic             bias_ld,
  output logic             fix_we,
  output logic             frame_end
);
  localparam logic [COL_W-1:0] NUM_ACT  = COL_W'(ACT_COLS);
  localparam logic [COL_W-1:0] DARK1    = COL_W'(ACT_COLS + 1);
  localparam logic [COL_W-1:0] LAST_IN  = COL_W'(ACT_COLS + DARK_COLS - 1);
  localparam logic [COL_W-1:0] LAST_ACT = COL_W'(ACT_COLS - 1);
  localparam logic [COL_W-1:0] COL_LIM  = COL_W'(ACT_COLS + DARK_COLS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  zb_state_t state;
  logic      accept;
  logic      row_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row   <= '0;
      col   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          row   <= '0;
          col   <= '0;
          state <= ST_GET;
        end
        ST_GET: if (pix_valid) begin
          col <= col + 1'b1;
          if (col == LAST_IN) state <= ST_BIAS;
        end
        ST_BIAS: begin
          col   <= '0;
          state <= ST_FIX;
        end
        ST_FIX: begin
          if (col == LAST_ACT) state <= ST_NEXT;
          else                 col   <= col + 1'b1;
        end
        ST_NEXT: begin
          col <= '0;
          if (row == LAST_ROW) state <= ST_IDLE;
          else begin
            row   <= row + 1'b1;
            state <= ST_GET;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // named internal events
  assign accept    = (state == ST_GET) && pix_valid;
  assign cap_we    = accept && (col < NUM_ACT);
  assign cap_dark0 = accept && (col == NUM_ACT);
  assign cap_dark1 = accept && (col == DARK1);
  assign bias_ld   = (state == ST_BIAS);
  assign fix_we    = (state == ST_FIX);
  assign row_adv   = (state == ST_NEXT);
  assign frame_end = row_adv && (row == LAST_ROW);
  assign busy      = (state != ST_IDLE);

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GET) |-> (col < COL_LIM)); // R3
  AST_NEW_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (row == '0 && col == '0 && busy)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !row_adv) |=> (row == $past(row))); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> busy); // R7
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy); // R7
endmodule

// File: rtl/zb_bias_unit.sv
module zb_bias_unit
  import zb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             cap_dark0,
  input  logic             cap_dark1,
  input  logic             bias_ld,
  output logic [PIX_W-1:0] bias
);
  logic [PIX_W-1:0] dark0, dark1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dark0 <= '0;
      dark1 <= '0;
      bias  <= '0;
    end else begin
      if (cap_dark0) dark0 <= pix_data;
      if (cap_dark1) dark1 <= pix_data;
      if (bias_ld)   bias  <= row_offset(dark0, dark1);
    end
  end

  AST_BIAS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bias_ld |=> ((bias <= (($past(dark0) > $past(dark1)) ? $past(dark0) : $past(dark1))) &&
                 (bias >= (($past(dark0) < $past(dark1)) ? $past(dark0) : $past(dark1))))); // R4
endmodule

// File: rtl/zb_frame_buf.sv
module zb_frame_buf #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] wr_q,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign wr_q = mem[waddr];
  assign rd_q = mem[rd_addr];
endmodule

// File: rtl/zb_row_corrector.sv
module zb_row_corrector
  import zb_pkg::*;
#(
  parameter int ROWS     = 64,
  parameter int ACT_COLS = 64,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(ACT_COLS + DARK_COLS + 1),
  localparam int CAW     = $clog2(ACT_COLS),
  localparam int ADDR_W  = ROW_W + CAW,
  localparam int BUS_AW  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  output logic [PIX_W-1:0]  bus_rdata
);
  localparam logic [COL_W-1:0] NUM_ACT = COL_W'(ACT_COLS);

  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              busy, cap_we, cap_dark0, cap_dark1, bias_ld, fix_we, frame_end;
  logic [PIX_W-1:0]  bias, buf_wr_q, buf_bus_q, wdata;
  logic [ADDR_W-1:0] waddr;
  logic              status_sel;

  zb_ctrl #(.ROWS(ROWS), .ACT_COLS(ACT_COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .row(row), .col(col), .busy(busy), .cap_we(cap_we),
    .cap_dark0(cap_dark0), .cap_dark1(cap_dark1), .bias_ld(bias_ld),
    .fix_we(fix_we), .frame_end(frame_end)
  );

  zb_bias_unit u_bias (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .cap_dark0(cap_dark0),
    .cap_dark1(cap_dark1), .bias_ld(bias_ld), .bias(bias)
  );

  assign waddr = {row, col[CAW-1:0]};
  assign wdata = fix_we ? sub_clamp(buf_wr_q, bias) : pix_data;

  zb_frame_buf #(.AW(ADDR_W), .DW(PIX_W)) u_buf (
    .clk(clk), .we(cap_we | fix_we), .waddr(waddr), .wdata(wdata),
    .wr_q(buf_wr_q), .rd_addr(bus_addr[ADDR_W-1:0]), .rd_q(buf_bus_q)
  );

  // the top address bit selects the status page; only its first word is live
  assign status_sel = bus_addr[BUS_AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      if (status_sel)
        bus_rdata <= (bus_addr[ADDR_W-1:0] == '0) ? {{(PIX_W-1){1'b0}}, busy} : '0;
      else
        bus_rdata <= buf_bus_q;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_we && fix_we)); // R6
  AST_FIX_COL: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> (col < NUM_ACT)); // R6
  AST_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> (wdata <= buf_wr_q)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R8
  AST_END_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> busy); // R7
endmodule

// File: tb/sim_zb_row_corrector.sv
module sim_zb_row_corrector;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_data = '0;
  logic        bus_rd = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_rdata;

  always #2 clk = ~clk;

  zb_row_corrector u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .pix_data(pix_data), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
  );

  int    n_chk = 0, n_fail = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  int    src [64][66];
  int    fr_row, fr_col, frame_no;

  // behavioural reference
  int    m_state, m_row, m_col, m_d0, m_d1, m_bias, m_rdata, m_a, m_v, m_i;
  int    m_mem [4096];
  string last_tag = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_row = 0; m_col = 0; m_rdata = 0;
    end else begin
      if (bus_rd) begin
        m_a = int'(bus_addr);
        if (m_a == 4096) begin
          m_rdata = (m_state != 0) ? 1 : 0; last_tag = "R7";
        end else if (m_a < 4096) begin
          m_rdata = m_mem[m_a];
          last_tag = (m_state == 3 && m_a == m_row*64 + m_col) ? "R9" : "R8";
        end else begin
          m_rdata = 0; last_tag = "R8";
        end
      end
      case (m_state)
        0: if (start) begin m_row = 0; m_col = 0; m_state = 1; end
        1: if (pix_valid) begin
          if (m_col < 64) m_mem[m_row*64 + m_col] = int'(pix_data);
          else if (m_col == 64) m_d0 = int'(pix_data);
          else m_d1 = int'(pix_data);
          if (m_col == 65) m_state = 2;
          m_col++;
        end
        2: begin m_bias = (m_d0 + m_d1) / 2; m_col = 0; m_state = 3; end
        3: begin
          m_i = m_row*64 + m_col;
          m_v = m_mem[m_i] - m_bias;
          m_mem[m_i] = (m_v < 0) ? 0 : m_v;
          if (m_col == 63) m_state = 4; else m_col++;
        end
        default: begin
          m_col = 0;
          if (m_row == 63) m_state = 0;
          else begin m_row++; m_state = 1; end
        end
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on)
      chk(bus_rdata === 8'(m_rdata), last_tag, int'(bus_rdata), m_rdata);
  end

  function automatic int expect_px(input int r, input int c);
    int off, d;
    off = (src[r][64] + src[r][65]) >> 1;
    d = src[r][c] - off;
    return (d > 0) ? d : 0;
  endfunction

  task automatic fill_frame();
    for (int r = 0; r < 64; r++) begin
      for (int c = 0; c < 64; c++) src[r][c] = $urandom_range(0, 255);
      case (r % 8)
        0: begin src[r][64] = 255; src[r][65] = 255; end
        1: begin src[r][64] = 0;   src[r][65] = 0;   end
        2: begin src[r][64] = 3;   src[r][65] = 4;   end
        default: begin src[r][64] = $urandom_range(0, 31); src[r][65] = $urandom_range(0, 31); end
      endcase
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input int a, output int v);
    bus_rd = 1'b1; bus_addr = 13'(a);
    step();
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  // mode 0: gaps, stray strobes and mixed reads; mode 1: gap-free with status polling
  task automatic drive_cycle(input int mode);
    int k;
    if (m_state == 1 && fr_row < 64 && (mode == 1 || $urandom_range(0, 3) != 0)) begin
      pix_valid = 1'b1; pix_data = 8'(src[fr_row][fr_col]);
      fr_col++;
      if (fr_col == 66) begin fr_col = 0; fr_row++; end
    end else if (m_state != 1 && (mode == 1 || $urandom_range(0, 3) == 0)) begin
      pix_valid = 1'b1; pix_data = 8'($urandom_range(0, 255));
    end else begin
      pix_valid = 1'b0;
    end
    if (mode == 1) begin
      bus_rd = 1'b1; bus_addr = 13'd4096;
      start = (m_state != 0 && $urandom_range(0, 99) == 0);
      return;
    end
    if (m_state != 0 && $urandom_range(0, 199) == 0) start = 1'b1;
    k = $urandom_range(0, 9);
    bus_rd = 1'b0;
    if (k == 0) begin bus_rd = 1'b1; bus_addr = 13'd4096; end
    else if (k == 1) begin bus_rd = 1'b1; bus_addr = 13'($urandom_range(4097, 8191)); end
    else if ((k == 2 || k == 3) && m_state == 3) begin
      bus_rd = 1'b1; bus_addr = 13'(m_row*64 + m_col);
    end else if ((k == 4 || k == 5) && (frame_no > 0 || m_row > 0)) begin
      bus_rd = 1'b1;
      bus_addr = 13'($urandom_range(0, (frame_no > 0) ? 4095 : m_row*64 - 1));
    end
  endtask

  task automatic run_frame(input int mode, output int busy_seen);
    int cyc;
    fr_row = 0; fr_col = 0; busy_seen = 0; cyc = 0;
    fill_frame();
    start = 1'b1;
    do begin
      drive_cycle(mode);
      if (cyc == 0) start = 1'b1;
      step();
      start = 1'b0;
      if (mode == 1) busy_seen += int'(bus_rdata[0]);
      cyc++;
    end while (m_state != 0 && cyc < 20000);
    pix_valid = 1'b0; bus_rd = 1'b0; start = 1'b0;
    step();
  endtask

  task automatic readback(input string tag);
    int v;
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) begin
        rd(r*64 + c, v);
        if (tag == "rows") begin
          if (r % 8 == 0)      chk(v == expect_px(r, c), "R5", v, expect_px(r, c));
          else if (r % 8 == 2) chk(v == expect_px(r, c), "R4", v, expect_px(r, c));
          else                 chk(v == expect_px(r, c), "R3", v, expect_px(r, c));
        end else chk(v == expect_px(r, c), tag, v, expect_px(r, c));
      end
  endtask

  initial begin
    int v, cnt;
    repeat (5) step();
    chk(bus_rdata === 8'd0, "R1", int'(bus_rdata), 0);
    rst_n = 1'b1;
    step();
    chk_on = 1'b1;
    // R1: strobes in idle do nothing
    for (int i = 0; i < 6; i++) begin
      pix_valid = 1'b1; pix_data = 8'(i * 40); step();
    end
    pix_valid = 1'b0;
    rd(4096, v); chk(v == 0, "R1", v, 0);

    frame_no = 0;
    run_frame(0, cnt);
    rd(4096, v); chk(v == 0, "R7", v, 0);
    readback("rows");
    rd(5000, v); chk(v == 0, "R8", v, 0);
    rd(4097, v); chk(v == 0, "R8", v, 0);
    rd(65, v);
    repeat (3) step();
    chk(int'(bus_rdata) == v, "R8", int'(bus_rdata), v);

    frame_no = 1;
    run_frame(0, cnt);
    readback("R2");

    frame_no = 2;
    run_frame(1, cnt);
    chk(cnt == 8448, "R6", cnt, 8448);
    readback("R6");

    chk_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule